// File: doc/BRIEF.md
# Sliced CRC-32 Engine

This block computes the reflected CRC-32 of a byte stream that arrives one whole word per clock. A word is 4 or 8 bytes wide, set by a parameter. Instead of stepping through the word bit by bit, the engine merges the running remainder into the low 32 bits of the word. It then splits the merged word into bytes and sends each byte to its own 256-entry lookup table.

Each table cancels a different span of polynomial coefficients, so all of the tables differ. The new remainder is the XOR of all lookup results. The tables are computed when the design is elaborated; no memory contents are loaded.

In the 8-byte form, the upper four bytes index their tables with raw input data. Those lookups therefore do not wait on the previous remainder.

A start pulse opens a message and sets the remainder to all ones. Each valid word that follows extends the message. The output always shows the finished CRC of the bytes seen so far, which is the inverted remainder. The value can therefore be appended to the message without further processing. A message that does not end on a word boundary is finished by a separate byte-wide engine.

A two-state controller tracks the message. State ST_IDLE is entered at reset; no message is open and valid words are ignored. A start pulse takes the transition IDLE_TO_OPEN into state ST_OPEN. In ST_OPEN, valid words are folded in. A further start pulse takes the transition OPEN_RESTART, which stays in ST_OPEN and re-initialises the remainder. Nothing leads from ST_OPEN back to ST_IDLE except reset.

Top module: `crc32_slicer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `crc` reads 32'h00000000 (remainder all ones) and the controller is in ST_IDLE.
- R2: A start pulse with `valid` low makes `crc` read 32'h00000000 in the following cycle.
- R3: A start pulse with `valid` high processes that word from a freshly initialised remainder, and the controller is in ST_OPEN in the following cycle.
- R4: In ST_OPEN, each valid word updates `crc` on the next clock. The new value is the reflected CRC-32 (polynomial 32'hEDB88320, initial value all ones, final inversion) of all bytes since the last start. Bytes are taken in order data[7:0] first, and within each byte the least significant bit first.
- R5: A cycle with both `start` and `valid` low leaves `crc` unchanged.
- R6: Before the first start after reset, valid words are ignored and `crc` stays 32'h00000000.
- R7: A start pulse in the middle of a message discards the bytes taken so far. The controller never leaves ST_OPEN except through reset.
- R8: Appending the output CRC of a 4-byte payload, least significant byte first, as the next four bytes yields the fixed residue `crc` = 32'h2144DF1C.
- R9: With SLICES = 4 (32-bit words), the engine gives the same per-byte result as R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new message and initialises the remainder |
| valid | input | 1 | Qualifies `data` as the next word of the message |
| data | input | 8*SLICES | Message word, first byte in bits [7:0] |
| crc | output | 32 | Finished CRC of the bytes taken since the last start |

## Verification
On every cycle, the assertions check the controller and the rules that hold the output steady. The output holds when the inputs are quiet, clears after a bare start, and ignores words before the first start. A start always leads to ST_OPEN, and ST_OPEN is never left.

The arithmetic can only be shown by the bench scenarios. These cover agreement with a bit-serial model over random multi-word messages with gaps, restarts in the middle of a message, the fixed residue after an appended CRC, and the 4-byte word variant.

// File: rtl/crc_slice_pkg.sv
package crc_slice_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef logic [255:0][31:0] lut_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } seq_state_e;

    // Remainder left by one byte followed by POS zero bytes, starting from zero.
    function automatic logic [31:0] lut_entry(input int unsigned pos, input logic [7:0] idx);
        logic [31:0] v;
        v = {24'h0, idx};
        for (int unsigned s = 0; s < 8 * (pos + 1); s++) begin
            v = v[0] ? ((v >> 1) ^ CRC_POLY_REFL) : (v >> 1);
        end
        return v;
    endfunction

    function automatic lut_t build_lut(input int unsigned pos);
        lut_t t;
        for (int n = 0; n < 256; n++) begin
            t[n] = lut_entry(pos, 8'(n));
        end
        return t;
    endfunction

endpackage

// File: rtl/crc_slice_rom.sv
module crc_slice_rom
    import crc_slice_pkg::*;
#(
    parameter int unsigned POS = 0
) (
    input  logic [7:0]  idx,
    output logic [31:0] val
);
    localparam lut_t LUT = build_lut(POS);

    assign val = LUT[idx];
endmodule

// File: rtl/crc_word_fold.sv
module crc_word_fold
    import crc_slice_pkg::*;
#(
    parameter int unsigned SLICES = 8
) (
    input  logic [31:0]           rem_in,
    input  logic [8*SLICES-1:0]   word,
    output logic [31:0]           rem_next
);
    localparam int unsigned WBITS = 8 * SLICES;

    logic [WBITS-1:0]             merged;
    logic [SLICES-1:0][31:0]      lk;

    // Only the low 32 bits see the remainder; higher bytes are raw data.
    assign merged = word ^ WBITS'(rem_in);

    for (genvar i = 0; i < SLICES; i++) begin : g_lane
        crc_slice_rom #(.POS(SLICES - 1 - i)) u_rom (
            .idx (merged[8*i +: 8]),
            .val (lk[i])
        );
    end

    always_comb begin
        rem_next = '0;
        for (int i = 0; i < SLICES; i++) begin
            rem_next = rem_next ^ lk[i];
        end
    end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc_slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       valid,
    output seq_state_e state,
    output logic       load_seed,
    output logic       advance
);
    seq_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = start ? ST_OPEN : ST_IDLE;
            ST_OPEN: state_nxt = ST_OPEN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_seed = start;
        advance   = valid && (start || (state == ST_OPEN));
    end
endmodule

// File: rtl/crc32_slicer.sv
module crc32_slicer
    import crc_slice_pkg::*;
#(
    parameter int unsigned SLICES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  valid,
    input  logic [8*SLICES-1:0]   data,
    output logic [31:0]           crc
);
    seq_state_e  seq_state;
    logic        load_seed;
    logic        advance;
    logic [31:0] rem_q;
    logic [31:0] rem_base;
    logic [31:0] rem_next;

    crc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .valid     (valid),
        .state     (seq_state),
        .load_seed (load_seed),
        .advance   (advance)
    );

    assign rem_base = load_seed ? CRC_SEED : rem_q;

    crc_word_fold #(.SLICES(SLICES)) u_fold (
        .rem_in   (rem_base),
        .word     (data),
        .rem_next (rem_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          rem_q <= CRC_SEED;
        else if (advance)    rem_q <= rem_next;
        else if (load_seed)  rem_q <= CRC_SEED;
    end

    assign crc = ~rem_q;
endmodule

// File: rtl/crc32_slicer_chk.sv
module crc32_slicer_chk
    import crc_slice_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        valid,
    input logic [31:0] crc,
    input seq_state_e  state
);
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !valid) |=> $stable(crc));                          // R5
    AST_BARE_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> (crc == 32'h0));                         // R2
    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(crc));                // R6
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_OPEN));                                 // R3
    AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |=> (state == ST_OPEN));                    // R7
endmodule

bind crc32_slicer crc32_slicer_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .valid (valid),
    .crc   (crc),
    .state (seq_state)
);

// File: tb/crc32_slicer_tb.sv
module crc32_slicer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        valid = 1'b0;
    logic [63:0] data64 = '0;
    logic [31:0] data32 = '0;
    logic [31:0] crc8;
    logic [31:0] crc4;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    logic [31:0] ref8 = 32'hFFFF_FFFF;
    logic [31:0] ref4 = 32'hFFFF_FFFF;
    bit          open8 = 1'b0;

    always #2 clk = ~clk;

    crc32_slicer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .data(data64), .crc(crc8)
    );
    crc32_slicer #(.SLICES(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .data(data32), .crc(crc4)
    );

    function automatic logic [31:0] feed(input logic [31:0] rem, input logic [63:0] d, input int nb);
        logic [31:0] r;
        r = rem;
        for (int b = 0; b < nb; b++) begin
            r = r ^ {24'h0, d[8*b +: 8]};
            for (int k = 0; k < 8; k++) begin
                if (r[0]) r = (r >> 1) ^ 32'hEDB88320;
                else      r = r >> 1;
            end
        end
        return r;
    endfunction

    // Behavioural reference, one update per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref8 = 32'hFFFF_FFFF; ref4 = 32'hFFFF_FFFF; open8 = 1'b0;
        end else begin
            if (start) begin
                ref8 = 32'hFFFF_FFFF; ref4 = 32'hFFFF_FFFF; open8 = 1'b1;
            end
            if (valid && open8) begin
                ref8 = feed(ref8, data64, 8);
                ref4 = feed(ref4, {32'h0, data32}, 4);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Compare both widths with the model on every cycle (R4, R9 and the scenario tag).
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, crc8, ~ref8);
            check({cur_req, "/R9"}, crc4, ~ref4);
        end
    end

    task automatic drive(input logic s, input logic v, input logic [63:0] d);
        @(negedge clk);
        start = s; valid = v; data64 = d; data32 = d[31:0];
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        check("R1", crc8, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", crc8, 32'h0);

        cur_req = "R6";
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, rnd64());
        drive(1'b0, 1'b0, '0);
        @(negedge clk);
        check("R6", crc8, 32'h0);

        cur_req = "R2";
        drive(1'b1, 1'b0, rnd64());
        drive(1'b0, 1'b0, '0);
        check("R2", crc8, 32'h0);

        cur_req = "R4";
        for (int m = 0; m < 25; m++) begin
            int nw;
            nw = 1 + ($urandom % 8);
            drive(1'b1, (m % 2) == 0, rnd64());
            for (int w = 0; w < nw; w++) begin
                cur_req = "R5";
                if (($urandom % 3) == 0) drive(1'b0, 1'b0, rnd64());
                cur_req = "R4";
                drive(1'b0, 1'b1, rnd64());
            end
            drive(1'b0, 1'b0, '0);
        end

        cur_req = "R3";
        begin
            logic [63:0] w0;
            w0 = rnd64();
            drive(1'b1, 1'b1, w0);
            drive(1'b0, 1'b0, '0);
            check("R3", crc8, ~feed(32'hFFFF_FFFF, w0, 8));
        end

        cur_req = "R7";
        begin
            logic [63:0] w1;
            drive(1'b1, 1'b1, rnd64());
            drive(1'b0, 1'b1, rnd64());
            w1 = rnd64();
            drive(1'b1, 1'b1, w1);
            drive(1'b0, 1'b0, '0);
            check("R7", crc8, ~feed(32'hFFFF_FFFF, w1, 8));
        end

        cur_req = "R8";
        for (int t = 0; t < 4; t++) begin
            logic [31:0] p;
            logic [31:0] c;
            p = $urandom;
            c = ~feed(32'hFFFF_FFFF, {32'h0, p}, 4);
            drive(1'b1, 1'b1, {c, p});
            drive(1'b0, 1'b0, '0);
            check("R8", crc8, 32'h2144DF1C);
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule